// File: doc/BRIEF.md
# Indirect Register Access Window

This block exposes one 64-bit host register that acts as a doorway into a separate, larger space of 16-bit registers. It does not map every indirect register into the host address map. Instead, the host writes one packed command word. That word names the direction, a 20-bit indirect address and a 16-bit data value. The block then carries out the access against its internal register array. The outcome is reported in the same host register: completion flags are OR-ed into the word, and on a read the fetched value replaces the data field.

Bits are numbered big-endian in this document: bit 0 is the most significant bit of the word, which is port bit 63. A command is accepted only while the block is idle. The access finishes two clock edges after acceptance, and the host then polls the window to see the flags. The indirect array has a parameterized depth. It is indexed by the low bits of the 20-bit address. Two scratch outputs show the address of the last command and the last value read.

Top module: `regwin_bridge`

## Requirements
- R1: After synchronous reset, the window reads 0, busy is 0, both scratch outputs are 0, and every indirect entry reads back as 0.
- R2: A command whose direction bit (big-endian bit 0, port bit 63) is 0 stores the data field into the indirect entry selected by the address. The data field is big-endian bits 48..63, port bits 15..0. The address field is big-endian bits 12..31, port bits 51..32.
- R3: When a write completes, the window equals the command word OR 0x00000000_82000000. This sets big-endian bits 32 and 38 (port bits 31 and 25) and leaves every other bit unchanged.
- R4: When a read completes (direction bit 1), port bits 15..0 of the window hold the addressed entry. The window is also OR-ed with 0x00000000_83000000, which sets big-endian bits 32, 38 and 39 (port bits 31, 25 and 24). Port bits 63..16 are otherwise unchanged.
- R5: A completed read copies the fetched value to the data scratch output. The address scratch output holds the 20-bit address of the most recent command.
- R6: An accepted command raises busy on the next edge. Busy stays high for exactly two cycles. The completion flags appear at the second edge after acceptance.
- R7: A host write issued while busy is ignored. The window keeps its contents, and no second access takes place.
- R8: An accepted host write replaces the whole window with the new word, which clears the flags left by the previous access.
- R9: Only the low log2(DEPTH) address bits select an entry. Addresses that differ only above those bits reach the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe for the window |
| host_wdata | input | 64 | Command word written by the host |
| host_rdata | output | 64 | Current window contents |
| busy | output | 1 | An indirect access is in progress |
| addr_scratch | output | 20 | Address of the most recent command |
| data_scratch | output | 16 | Value fetched by the most recent read |

## Verification
The hardest situation to reach is a host write that lands while an access is in progress. The window must stay untouched, and the array must still be written with the first command's data alone. The stimulus drives a second, conflicting command in the cycle right after acceptance. It then reads the entry back to show that only the first value was stored. Address aliasing is the other case: a write with high address bits set must be visible to a read of the plain low index. A further vector arrives with completion flags already set in the command word, to show that the OR merge and the data replacement do not depend on what the host wrote into those positions.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int WORD_W = 64;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;

    // convert a big-endian bit number into a port bit index
    function automatic int le_pos(input int be_bit);
        return WORD_W - 1 - be_bit;
    endfunction

    localparam int OP_POS    = le_pos(0);
    localparam int ADDR_MSB  = le_pos(12);
    localparam int ADDR_LSB  = le_pos(31);
    localparam int DATA_MSB  = le_pos(48);
    localparam int DATA_LSB  = le_pos(63);
    localparam int FLG_DONE  = le_pos(32);
    localparam int FLG_ACK   = le_pos(38);
    localparam int FLG_RDVAL = le_pos(39);

    localparam logic [WORD_W-1:0] WR_FLAGS =
        (64'd1 << FLG_DONE) | (64'd1 << FLG_ACK);
    localparam logic [WORD_W-1:0] RD_FLAGS = WR_FLAGS | (64'd1 << FLG_RDVAL);
    localparam logic [WORD_W-1:0] DATA_MASK =
        {{(WORD_W-DATA_W){1'b0}}, {DATA_W{1'b1}}} << DATA_LSB;

    typedef struct packed {
        logic              is_read;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LATCH  = 2'd1,
        ST_COMMIT = 2'd2
    } seq_state_e;

    function automatic cmd_t unpack_cmd(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.is_read = w[OP_POS];
        c.addr    = w[ADDR_MSB:ADDR_LSB];
        c.data    = w[DATA_MSB:DATA_LSB];
        return c;
    endfunction

endpackage

// File: rtl/regwin_seq.sv
module regwin_seq
    import regwin_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic latch_en,
    output logic commit_en
);

    seq_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (start) state_q <= ST_LATCH;
                ST_LATCH:  state_q <= ST_COMMIT;
                ST_COMMIT: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign latch_en  = (state_q == ST_LATCH);
    assign commit_en = (state_q == ST_COMMIT);

    // R6: the access is exactly two states long
    p_latch_follows_start_r6: assert property (@(posedge clk) disable iff (rst)
        (start && state_q == ST_IDLE) |=> (state_q == ST_LATCH));
    p_commit_returns_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COMMIT) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/regwin_store.sv
module regwin_store
    import regwin_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              latch_en,
    input  logic              commit_wr,
    output logic [DATA_W-1:0] rd_hold
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (commit_wr) begin
            mem_q[idx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           rd_hold <= '0;
        else if (latch_en) rd_hold <= mem_q[idx];
    end

    // R2: array writes happen only in the commit phase, never while fetching
    p_no_write_in_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        !(latch_en && commit_wr));

endmodule

// File: rtl/regwin_merge.sv
module regwin_merge
    import regwin_pkg::*;
(
    input  logic [WORD_W-1:0] win,
    input  logic              is_read,
    input  logic [DATA_W-1:0] rd_val,
    output logic [WORD_W-1:0] merged
);

    logic [WORD_W-1:0] placed;

    always_comb begin
        placed = {{(WORD_W-DATA_W){1'b0}}, rd_val} << DATA_LSB;
        if (is_read) merged = (win & ~DATA_MASK) | placed | RD_FLAGS;
        else         merged = win | WR_FLAGS;
    end

endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
    import regwin_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic [63:0]       host_wdata,
    output logic [63:0]       host_rdata,
    output logic              busy,
    output logic [19:0]       addr_scratch,
    output logic [15:0]       data_scratch
);

    logic [WORD_W-1:0] win_q;
    logic [WORD_W-1:0] merged;
    logic [DATA_W-1:0] rd_hold;
    logic              accept, latch_en, commit_en;
    cmd_t              cmd;

    assign cmd    = unpack_cmd(win_q);
    assign accept = host_wr_en && !busy;

    regwin_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .busy      (busy),
        .latch_en  (latch_en),
        .commit_en (commit_en)
    );

    regwin_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .idx       (cmd.addr[IDX_W-1:0]),
        .wdata     (cmd.data),
        .latch_en  (latch_en),
        .commit_wr (commit_en && !cmd.is_read),
        .rd_hold   (rd_hold)
    );

    regwin_merge u_merge (
        .win     (win_q),
        .is_read (cmd.is_read),
        .rd_val  (rd_hold),
        .merged  (merged)
    );

    always_ff @(posedge clk) begin
        if (rst)            win_q <= '0;
        else if (accept)    win_q <= host_wdata;
        else if (commit_en) win_q <= merged;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_scratch <= '0;
            data_scratch <= '0;
        end else begin
            if (latch_en)                 addr_scratch <= cmd.addr;
            if (commit_en && cmd.is_read) data_scratch <= rd_hold;
        end
    end

    assign host_rdata = win_q;

    // R8: an accepted write replaces the whole window
    p_accept_load_r8: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && !busy) |=> (win_q == $past(host_wdata)));
    // R7: the window cannot change during the fetch phase
    p_hold_in_fetch_r7: assert property (@(posedge clk) disable iff (rst)
        latch_en |=> $stable(win_q));
    // R3: a finished write sets its two flags and keeps the data field
    p_write_flags_r3: assert property (@(posedge clk) disable iff (rst)
        (commit_en && !cmd.is_read) |=>
            (win_q[FLG_DONE] && win_q[FLG_ACK] &&
             win_q[DATA_MSB:DATA_LSB] == $past(win_q[DATA_MSB:DATA_LSB])));
    // R4: a finished read sets three flags and keeps the upper half
    p_read_flags_r4: assert property (@(posedge clk) disable iff (rst)
        (commit_en && cmd.is_read) |=>
            (win_q[FLG_DONE] && win_q[FLG_ACK] && win_q[FLG_RDVAL] &&
             win_q[63:32] == $past(win_q[63:32])));
    // R5: the data scratch mirrors the value returned in the window
    p_scratch_match_r5: assert property (@(posedge clk) disable iff (rst)
        (commit_en && cmd.is_read) |=> (data_scratch == win_q[DATA_MSB:DATA_LSB]));

endmodule

// File: tb/test_regwin_bridge.sv
module test_regwin_bridge;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr_en;
    logic [63:0] host_wdata;
    logic [63:0] host_rdata;
    logic        busy;
    logic [19:0] addr_scratch;
    logic [15:0] data_scratch;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    regwin_bridge i_regwin_bridge (
        .clk          (clk),
        .rst          (rst),
        .host_wr_en   (host_wr_en),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .busy         (busy),
        .addr_scratch (addr_scratch),
        .data_scratch (data_scratch)
    );

    // {command, expected window after completion}
    localparam logic [127:0] VEC [8] = '{
        {64'h0000_0005_0000_BEEF, 64'h0000_0005_8200_BEEF},
        {64'h0000_00FF_0000_1234, 64'h0000_00FF_8200_1234},
        {64'h8000_0005_0000_0000, 64'h8000_0005_8300_BEEF},
        {64'h8000_00FF_0000_FFFF, 64'h8000_00FF_8300_1234},
        {64'h8000_0010_0000_5555, 64'h8000_0010_8300_0000},
        {64'h7FFA_BC05_0011_0F0F, 64'h7FFA_BC05_8211_0F0F},
        {64'h8000_0005_0000_0000, 64'h8000_0005_8300_0F0F},
        {64'h8000_00FF_0100_0000, 64'h8000_00FF_8300_1234}
    };

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, then check after each of the next three rising edges
    task automatic run_cmd(input logic [63:0] cmd, input logic [63:0] exp, input string tag);
        host_wr_en = 1'b1;
        host_wdata = cmd;
        @(negedge clk);
        host_wr_en = 1'b0;
        chk(host_rdata, cmd, "R8 window loaded, old flags gone");
        chk({63'd0, busy}, 64'd1, "R6 busy after accept");
        @(negedge clk);
        chk({63'd0, busy}, 64'd1, "R6 busy second cycle");
        chk(host_rdata, cmd, "R6 no flags before completion");
        @(negedge clk);
        chk({63'd0, busy}, 64'd0, "R6 idle after two cycles");
        chk(host_rdata, exp, tag);
        chk({44'd0, addr_scratch}, {44'd0, cmd[51:32]}, "R5 address scratch");
        if (cmd[63]) chk({48'd0, data_scratch}, {48'd0, exp[15:0]}, "R5 data scratch");
    endtask

    initial begin
        rst        = 1'b1;
        host_wr_en = 1'b0;
        host_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(host_rdata, 64'd0, "R1 window reset");
        chk({63'd0, busy}, 64'd0, "R1 busy reset");
        chk({28'd0, data_scratch, addr_scratch}, 64'd0, "R1 scratch reset");
        run_cmd(64'h8000_0033_0000_0000, 64'h8000_0033_8300_0000, "R1 entry reads zero");

        for (int k = 0; k < 8; k++) begin
            run_cmd(VEC[k][127:64], VEC[k][63:0],
                    VEC[k][127] ? "R2 R4 read result" : "R3 write result");
        end

        // R9: high address bits ignored when indexing
        run_cmd(64'h8000_0105_0000_0000, 64'h8000_0105_8300_0F0F, "R9 alias read");

        // R7: second host write while busy is dropped
        host_wr_en = 1'b1;
        host_wdata = 64'h0000_0022_0000_AAAA;
        @(negedge clk);
        host_wdata = 64'h0000_0022_0000_5555;
        @(negedge clk);
        host_wr_en = 1'b0;
        chk(host_rdata, 64'h0000_0022_0000_AAAA, "R7 window kept while busy");
        @(negedge clk);
        chk(host_rdata, 64'h0000_0022_8200_AAAA, "R7 first command completes");
        chk({63'd0, busy}, 64'd0, "R7 no second access");
        run_cmd(64'h8000_0022_0000_0000, 64'h8000_0022_8300_AAAA, "R7 R2 stored value");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule